// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Sequencer

This block sits next to the main command controller of an SDRAM interface and schedules refresh work on its behalf. An interval timer adds one owed refresh every `T_REFI` clock cycles. When the main controller reports that it is idle, the block pays off the owed refreshes with AUTO REFRESH commands. While the controller is busy, refreshes are postponed. The debt is capped at eight. When it reaches the cap, a refresh is forced regardless of the busy input. Each refresh occupies the memory for `T_RFC` cycles. During that time CKE stays high and the ready flag stays low. The address bus is not used.

The block also handles self-refresh. A request taken in the idle state issues the refresh encoding with CKE low, and CKE then stays low. Exit starts when the request is withdrawn and the clock is reported stable. CKE goes high, and the block issues NOPs for `T_XSNR` cycles. It then issues a DLL-reset mode-load command and waits `DLL_LOCK` NOP cycles before it raises ready again. On return, the debt is zero and the interval timer starts a fresh period.

The sequencer has eight states:
- `ST_IDLE`: ready.
- `ST_AR_ISSUE`: the refresh command.
- `ST_AR_HOLD`: the remainder of the refresh period.
- `ST_SR_ENTER`: self-refresh entry.
- `ST_SR_SLEEP`: CKE low.
- `ST_SR_WAKE`: the NOP period after CKE rises.
- `ST_DLL_LOAD`: the mode-load command.
- `ST_DLL_LOCK`: the NOP lockout.

The transitions are:
- IDLE goes to AR_ISSUE when the debt is full, or when debt is owed and the controller is idle.
- IDLE goes to SR_ENTER on a request, provided the debt is not full.
- AR_ISSUE goes to AR_HOLD.
- AR_HOLD goes back to AR_ISSUE (catch-up) or to IDLE when the period ends.
- SR_ENTER goes to SR_SLEEP.
- SR_SLEEP goes to SR_WAKE when the request is low and the clock is stable.
- SR_WAKE goes to DLL_LOAD after `T_XSNR` cycles.
- DLL_LOAD goes to DLL_LOCK.
- DLL_LOCK goes to IDLE after `DLL_LOCK` cycles.

Top module: `refresh_scheduler`

## Requirements
- R1: Command codes are 2'b00 NOP, 2'b01 refresh and 2'b10 DLL-reset mode load. After reset `cmd_o` is NOP, `cke_o` is 1 and `ready_o` is 1. Whenever `ready_o` is 1, `cmd_o` is NOP and `cke_o` is 1.
- R2: With `busy_i` low, refresh commands (code 01 with `cke_o` high) follow each other exactly `T_REFI` cycles apart.
- R3: The owed-refresh count never exceeds eight. With `busy_i` held high from the cycle after a refresh that cleared the debt, the next refresh is forced exactly 8*`T_REFI` cycles after it.
- R4: For the `T_RFC`-1 cycles after a refresh command, `cke_o` is 1, `cmd_o` is NOP and `ready_o` is 0. With no debt left, `ready_o` returns to 1 `T_RFC` cycles after the command.
- R5: When `busy_i` falls with N refreshes owed, N refresh commands follow, each exactly `T_RFC` cycles after the previous one.
- R6: A self-refresh request in the idle state produces, on the next cycle, one cycle of code 01 with `cke_o` low. A request raised during a refresh period is held off, and entry then occurs `T_RFC`+1 cycles after that refresh command.
- R7: In self-refresh, `cke_o` is 0, `cmd_o` is NOP and `ready_o` is 0 until `sr_req_i` is low and `clk_stable_i` is high together.
- R8: On exit, `cke_o` rises and `T_XSNR` NOP cycles follow, starting with the rise cycle. One cycle of code 10 comes next.
- R9: After the DLL-reset command, `cmd_o` stays NOP and `ready_o` stays 0 for `DLL_LOCK` cycles. `ready_o` rises `DLL_LOCK`+1 cycles after the command.
- R10: Self-refresh clears the debt and restarts the interval. With `busy_i` high from the cycle `ready_o` rises, the first refresh is forced 8*`T_REFI`+1 cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy_i | input | 1 | Main controller has work in progress; postpone refreshes |
| sr_req_i | input | 1 | Level request to enter (high) or leave (low) self-refresh |
| clk_stable_i | input | 1 | Memory clock reported stable; allows the exit sequence to begin |
| cmd_o | output | 2 | Command code: 00 NOP, 01 refresh, 10 DLL-reset mode load |
| cke_o | output | 1 | Clock-enable level to the memory |
| ready_o | output | 1 | Main controller may issue its own commands |

## Verification
Refresh timing is tried under three input patterns, and each tells apart a different fault:
- With `busy_i` always low, the spacing between refreshes exposes an interval timer that is off by one.
- With `busy_i` held high, the delay to the forced refresh exposes a debt cap other than eight.
- When `busy_i` is then released, counting the back-to-back refreshes and measuring the gap after them shows whether the debt was decremented correctly.

Self-refresh is entered twice: once from idle, and once with the request raised inside a refresh period. Both timings must match, which separates correct request gating from premature acceptance. The exit checks are the wake length, the mode-load position, the lockout length and the first forced refresh after return. Together these detect a debt that is not cleared or an interval timer that is not restarted.

// File: rtl/rfsh_pkg.sv
`timescale 1ns/1ps
package rfsh_pkg;

    typedef enum logic [1:0] {
        CMD_NOP     = 2'b00,
        CMD_REF     = 2'b01,
        CMD_DLL_MRS = 2'b10
    } cmd_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_AR_ISSUE,
        ST_AR_HOLD,
        ST_SR_ENTER,
        ST_SR_SLEEP,
        ST_SR_WAKE,
        ST_DLL_LOAD,
        ST_DLL_LOCK
    } seq_state_e;

endpackage

// File: rtl/rfsh_interval_timer.sv
`timescale 1ns/1ps
module rfsh_interval_timer #(
    parameter int T_REFI = 780
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic tick_o
);
    localparam int CW = (T_REFI > 2) ? $clog2(T_REFI) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(T_REFI - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= RELOAD;
        end else if (restart_i || cnt_q == '0) begin
            cnt_q <= RELOAD;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign tick_o = (cnt_q == '0) && !restart_i;

    // R2: consecutive ticks are never adjacent
    p_tick_sparse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

endmodule

// File: rtl/rfsh_debt_counter.sv
`timescale 1ns/1ps
module rfsh_debt_counter #(
    parameter int MAX_DEBT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic owe_i,
    input  logic pay_i,
    output logic pending_o,
    output logic full_o
);
    localparam int DW = $clog2(MAX_DEBT + 1);
    localparam logic [DW-1:0] CAP = DW'(MAX_DEBT);

    logic [DW-1:0] debt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            debt_q <= '0;
        end else if (clear_i) begin
            debt_q <= '0;
        end else begin
            unique case ({owe_i, pay_i})
                2'b10:   debt_q <= debt_q + 1'b1;
                2'b01:   debt_q <= debt_q - 1'b1;
                default: debt_q <= debt_q;
            endcase
        end
    end

    assign pending_o = (debt_q != '0);
    assign full_o    = (debt_q == CAP);

    // R3: postponed refreshes are bounded
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        debt_q <= CAP);

    // R5: a refresh is only paid when one is owed
    p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pay_i |-> pending_o);

    // R5: without a clear the debt moves by at most one per cycle
    p_debt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> (debt_q == $past(debt_q) || debt_q == $past(debt_q) + 1'b1
                      || debt_q + 1'b1 == $past(debt_q)));

endmodule

// File: rtl/rfsh_seq_fsm.sv
`timescale 1ns/1ps
module rfsh_seq_fsm
    import rfsh_pkg::*;
#(
    parameter int T_RFC    = 10,
    parameter int T_XSNR   = 20,
    parameter int DLL_LOCK = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_i,
    input  logic sr_req_i,
    input  logic clk_stable_i,
    input  logic pending_i,
    input  logic full_i,
    output cmd_e cmd_o,
    output logic cke_o,
    output logic ready_o,
    output logic pay_o,
    output logic sleep_o
);
    localparam int TMAX = (T_RFC > T_XSNR) ? ((T_RFC > DLL_LOCK) ? T_RFC : DLL_LOCK)
                                           : ((T_XSNR > DLL_LOCK) ? T_XSNR : DLL_LOCK);
    localparam int TW = $clog2(TMAX + 1);
    localparam logic [TW-1:0] HOLD_LAST = TW'(T_RFC - 2);
    localparam logic [TW-1:0] WAKE_LAST = TW'(T_XSNR - 1);
    localparam logic [TW-1:0] LOCK_LAST = TW'(DLL_LOCK - 1);

    seq_state_e state_q, state_nx;
    logic [TW-1:0] tmr_q;
    logic          refresh_due;

    assign refresh_due = full_i || (pending_i && !busy_i);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // dwell timer: counts cycles spent in the current state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else if (state_q != state_nx) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_q + 1'b1;
        end
    end

    // transitions
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (full_i)           state_nx = ST_AR_ISSUE;
                else if (sr_req_i)    state_nx = ST_SR_ENTER;
                else if (refresh_due) state_nx = ST_AR_ISSUE;
            end
            ST_AR_ISSUE: state_nx = ST_AR_HOLD;
            ST_AR_HOLD: begin
                if (tmr_q == HOLD_LAST)
                    state_nx = refresh_due ? ST_AR_ISSUE : ST_IDLE;
            end
            ST_SR_ENTER: state_nx = ST_SR_SLEEP;
            ST_SR_SLEEP: begin
                if (!sr_req_i && clk_stable_i) state_nx = ST_SR_WAKE;
            end
            ST_SR_WAKE: begin
                if (tmr_q == WAKE_LAST) state_nx = ST_DLL_LOAD;
            end
            ST_DLL_LOAD: state_nx = ST_DLL_LOCK;
            ST_DLL_LOCK: begin
                if (tmr_q == LOCK_LAST) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cmd_o   = CMD_NOP;
        cke_o   = 1'b1;
        ready_o = 1'b0;
        pay_o   = 1'b0;
        sleep_o = 1'b0;
        unique case (state_q)
            ST_IDLE:     ready_o = !full_i;
            ST_AR_ISSUE: begin
                cmd_o = CMD_REF;
                pay_o = 1'b1;
            end
            ST_AR_HOLD:  ;
            ST_SR_ENTER: begin
                cmd_o   = CMD_REF;
                cke_o   = 1'b0;
                sleep_o = 1'b1;
            end
            ST_SR_SLEEP: begin
                cke_o   = 1'b0;
                sleep_o = 1'b1;
            end
            ST_SR_WAKE:  sleep_o = 1'b1;
            ST_DLL_LOAD: begin
                cmd_o   = CMD_DLL_MRS;
                sleep_o = 1'b1;
            end
            ST_DLL_LOCK: sleep_o = 1'b1;
            default: ;
        endcase
    end

    // R1: ready only while the command bus is quiet and CKE is high
    p_ready_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (cmd_o == CMD_NOP && cke_o));

    // R4: the cycle after a refresh keeps CKE high with the controller locked out
    p_refresh_cke_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_REF && cke_o) |=> (cke_o && !ready_o && cmd_o == CMD_NOP));

    // R6: self-refresh entry only out of the idle state
    p_sr_from_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_REF && !cke_o) |-> ($past(state_q) == ST_IDLE));

    // R8: the DLL reset follows a NOP cycle with CKE already high
    p_dll_after_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_DLL_MRS) |-> ($past(cke_o) && $past(cmd_o) == CMD_NOP
                                    && $past(state_q) == ST_SR_WAKE));

    // R9: ready reappears after the lockout only when the full count is spent
    p_lock_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ready_o) && $past(state_q) == ST_DLL_LOCK) |-> ($past(tmr_q) == LOCK_LAST));

endmodule

// File: rtl/refresh_scheduler.sv
`timescale 1ns/1ps
module refresh_scheduler #(
    parameter int T_REFI   = 780,
    parameter int T_RFC    = 10,
    parameter int T_XSNR   = 20,
    parameter int DLL_LOCK = 200,
    parameter int MAX_DEBT = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       busy_i,
    input  logic       sr_req_i,
    input  logic       clk_stable_i,
    output logic [1:0] cmd_o,
    output logic       cke_o,
    output logic       ready_o
);
    import rfsh_pkg::*;

    logic tick;
    logic sleep;
    logic pay;
    logic pending;
    logic full;
    cmd_e cmd;

    rfsh_interval_timer #(.T_REFI(T_REFI)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (sleep),
        .tick_o    (tick)
    );

    rfsh_debt_counter #(.MAX_DEBT(MAX_DEBT)) u_debt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (sleep),
        .owe_i     (tick),
        .pay_i     (pay),
        .pending_o (pending),
        .full_o    (full)
    );

    rfsh_seq_fsm #(
        .T_RFC    (T_RFC),
        .T_XSNR   (T_XSNR),
        .DLL_LOCK (DLL_LOCK)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .busy_i       (busy_i),
        .sr_req_i     (sr_req_i),
        .clk_stable_i (clk_stable_i),
        .pending_i    (pending),
        .full_i       (full),
        .cmd_o        (cmd),
        .cke_o        (cke_o),
        .ready_o      (ready_o),
        .pay_o        (pay),
        .sleep_o      (sleep)
    );

    assign cmd_o = cmd;

endmodule

// File: tb/tb_refresh_scheduler.sv
`timescale 1ns/1ps
module tb_refresh_scheduler;

    localparam int REFI = 60;
    localparam int RFC  = 6;
    localparam int XSNR = 8;
    localparam int LOCK = 200;
    localparam logic [1:0] C_NOP = 2'b00;
    localparam logic [1:0] C_REF = 2'b01;
    localparam logic [1:0] C_MRS = 2'b10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       busy_i = 1'b0;
    logic       sr_req_i = 1'b0;
    logic       clk_stable_i = 1'b1;
    logic [1:0] cmd_o;
    logic       cke_o;
    logic       ready_o;

    int total = 0;
    int fails = 0;

    always #10 clk = ~clk;

    refresh_scheduler #(
        .T_REFI(REFI), .T_RFC(RFC), .T_XSNR(XSNR), .DLL_LOCK(LOCK), .MAX_DEBT(8)
    ) dut (
        .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .sr_req_i(sr_req_i),
        .clk_stable_i(clk_stable_i), .cmd_o(cmd_o), .cke_o(cke_o), .ready_o(ready_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // cycles until cmd/cke match, -1 on timeout
    task automatic wait_cmd(input logic [1:0] c, input logic k, input int limit, output int n);
        bit found = 0;
        n = -1;
        for (int i = 1; i <= limit && !found; i++) begin
            @(negedge clk);
            if (cmd_o == c && cke_o == k) begin
                n = i;
                found = 1;
            end
        end
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(cmd_o == C_NOP && cke_o && ready_o, "R1 reset state", {cmd_o, cke_o, ready_o}, 4'b0011);
    endtask

    task automatic t_steady;
        int n;
        bit bad;
        wait_cmd(C_REF, 1'b1, 4 * REFI, n);
        chk(n > 0, "R2 first refresh seen", n, 1);
        for (int r = 0; r < 3; r++) begin
            wait_cmd(C_REF, 1'b1, 2 * REFI, n);
            chk(n == REFI, "R2 idle refresh spacing", n, REFI);
        end
        bad = 0;
        for (int i = 1; i < RFC; i++) begin
            @(negedge clk);
            if (!(cke_o && cmd_o == C_NOP && !ready_o)) bad = 1;
        end
        chk(!bad, "R4 refresh period holds CKE, NOP, not ready", bad, 0);
        @(negedge clk);
        chk(ready_o == 1'b1, "R4 ready after tRFC", ready_o, 1);
    endtask

    task automatic t_postpone;
        int n;
        wait_cmd(C_REF, 1'b1, 2 * REFI, n);
        busy_i = 1'b1;
        wait_cmd(C_REF, 1'b1, 10 * REFI, n);
        chk(n == 8 * REFI, "R3 forced refresh at debt eight", n, 8 * REFI);
        busy_i = 1'b0;
        for (int r = 0; r < 7; r++) begin
            wait_cmd(C_REF, 1'b1, 2 * REFI, n);
            chk(n == RFC, "R5 catch-up spacing", n, RFC);
        end
        wait_cmd(C_REF, 1'b1, 2 * REFI, n);
        chk(n == REFI - 7 * RFC, "R5 catch-up count is seven", n, REFI - 7 * RFC);
    endtask

    task automatic t_exit_and_return;
        int n;
        bit bad;
        bad = 0;
        repeat (30) begin
            @(negedge clk);
            if (!(!cke_o && cmd_o == C_NOP && !ready_o)) bad = 1;
        end
        chk(!bad, "R7 asleep while requested", bad, 0);
        clk_stable_i = 1'b0;
        sr_req_i = 1'b0;
        bad = 0;
        repeat (20) begin
            @(negedge clk);
            if (cke_o) bad = 1;
        end
        chk(!bad, "R7 stays asleep until clock stable", bad, 0);
        clk_stable_i = 1'b1;
        @(negedge clk);
        chk(cke_o && cmd_o == C_NOP, "R8 CKE rises on exit", {cmd_o, cke_o}, 1);
        wait_cmd(C_MRS, 1'b1, 4 * XSNR, n);
        chk(n == XSNR, "R8 DLL reset after tXSNR", n, XSNR);
        bad = 0;
        n = -1;
        for (int i = 1; i <= LOCK + 5 && n < 0; i++) begin
            @(negedge clk);
            if (ready_o) n = i;
            else if (cmd_o != C_NOP || !cke_o) bad = 1;
        end
        chk(n == LOCK + 1, "R9 lockout length", n, LOCK + 1);
        chk(!bad, "R9 NOPs during lockout", bad, 0);
        busy_i = 1'b1;
        wait_cmd(C_REF, 1'b1, 10 * REFI, n);
        chk(n == 8 * REFI + 1, "R10 debt cleared and interval restarted", n, 8 * REFI + 1);
        busy_i = 1'b0;
    endtask

    task automatic t_sr_during_refresh;
        int n;
        wait_cmd(C_REF, 1'b1, 2 * REFI, n);
        sr_req_i = 1'b1;
        wait_cmd(C_REF, 1'b0, 4 * RFC, n);
        chk(n == RFC + 1, "R6 request held off during refresh", n, RFC + 1);
        t_exit_and_return();
    endtask

    task automatic t_sr_from_idle;
        int n;
        repeat (2 * REFI) @(negedge clk);
        wait_cmd(C_REF, 1'b1, 2 * REFI, n);
        repeat (RFC + 2) @(negedge clk);
        chk(ready_o == 1'b1, "R6 idle before request", ready_o, 1);
        sr_req_i = 1'b1;
        wait_cmd(C_REF, 1'b0, 4 * RFC, n);
        chk(n == 1, "R6 entry from idle next cycle", n, 1);
        @(negedge clk);
        chk(!cke_o && cmd_o == C_NOP, "R7 CKE low after entry", {cmd_o, cke_o}, 0);
        t_exit_and_return();
    endtask

    initial begin
        t_reset();
        t_steady();
        t_postpone();
        t_sr_during_refresh();
        t_sr_from_idle();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #(200000 * 20);
        total++;
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule